// File: doc/BRIEF.md
# Transparent Translation Window Matcher

This block decides, for every memory access, whether the access falls inside one of two transparent translation windows and may therefore skip the page table lookup entirely. A window is described by a 32-bit register that carries an enable bit, an upper-address base byte, a per-bit don't-care mask for that byte, a privilege-mode selector and a write-protect bit. A set of two windows exists for data accesses and a second set of two for instruction fetches. The function code of the access picks the set.

When a window matches, the physical address is the logical address unchanged. A write into a write-protected window requests a bus error, except during a test-mode probe, which only reports the match. A function code that marks neither a data access nor a program access is flagged as illegal and never matches. The windows work independently of whether paged translation is switched on, so the block has no enable of its own. All results are registered and appear one clock after the access is presented.

Top module: `xlat_bypass_top`

## Requirements
- R1: While synchronous reset `rst` is high at a rising edge, the following edge leaves `hit`, `busErr`, `illegalFc` at 0 and `paddr` at 0.
- R2: Function code bit 0 set selects the data windows (`dataWin0`/`dataWin1`). With bit 0 clear and bit 1 set, the instruction windows (`instWin0`/`instWin1`) are used. Bit 2 set marks a supervisor access.
- R3: A function code with bits 1:0 both zero raises `illegalFc` and gives `hit` = 0 and `busErr` = 0.
- R4: Window register bit 15 is the enable. A window with bit 15 clear never matches, whatever its other fields hold.
- R5: Window bits 31:24 hold the base and bits 23:16 hold a mask. Address bit 24+k must equal base bit k unless mask bit k is 1, in which case that bit is ignored.
- R6: Window bits 14:13 select the mode. 0 matches user accesses only (function code bit 2 clear). 1 matches supervisor accesses only. 2 and 3 match both.
- R7: When both windows of the chosen set match, window 0 wins and its write-protect bit alone decides the fault.
- R8: On a hit `paddr` equals the logical address that was presented. On a miss `paddr` is 0.
- R9: Window bit 2 is write protect. On a hit in such a window, a write (`isWrite` = 1) raises `busErr` unless `probe` = 1. Reads never raise `busErr`.
- R10: Every output reflects the inputs present at the previous rising edge. The inputs have no combinational effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| laddr | input | 32 | Logical address of the access |
| fcode | input | 3 | Function code: bit 2 supervisor, bit 1 program, bit 0 data |
| isWrite | input | 1 | 1 for a write access, 0 for a read |
| probe | input | 1 | Test-mode probe; suppresses the write-protect fault |
| dataWin0 | input | 32 | Data window 0 register (higher priority) |
| dataWin1 | input | 32 | Data window 1 register |
| instWin0 | input | 32 | Instruction window 0 register (higher priority) |
| instWin1 | input | 32 | Instruction window 1 register |
| hit | output | 1 | Access matched an enabled window |
| paddr | output | 32 | Pass-through physical address on a hit, 0 otherwise |
| busErr | output | 1 | Write-protect fault request |
| illegalFc | output | 1 | Function code was neither data nor program |

## Verification
Each of `hit`, `paddr`, `busErr` and `illegalFc` is due exactly one rising edge after the access is applied. The bench therefore drives every vector on a falling edge and compares on the next falling edge, halfway between that rising edge and the one after. One directed check also samples shortly after the drive, before any rising edge, and confirms that the outputs still show the previous access. The reset check holds inputs that would match while reset is high, so a leak through the registers would show up as a nonzero output.

// File: rtl/xlat_bypass_pkg.sv
package xlat_bypass_pkg;

  // Field positions inside a window register; the compare logic decodes these.
  localparam int WIN_W      = 32;
  localparam int EN_BIT     = 15;
  localparam int WP_BIT     = 2;
  localparam int MODE_HI    = 14;
  localparam int MODE_LO    = 13;
  localparam int BASE_HI    = 31;
  localparam int MASK_HI    = 23;

  typedef enum logic [1:0] {
    MODE_USER  = 2'd0,
    MODE_SUPER = 2'd1,
    MODE_ANYA  = 2'd2,
    MODE_ANYB  = 2'd3
  } winMode_t;

  // Strobes from the control decode to the datapath.
  typedef struct packed {
    logic selData;
    logic selInst;
    logic superMode;
    logic writeChk;
    logic badFc;
  } ctrlStrobe_t;

endpackage

// File: rtl/xlat_bypass_ctrl.sv
module xlat_bypass_ctrl
  import xlat_bypass_pkg::*;
#(
  parameter int FC_W = 3
) (
  input  logic [FC_W-1:0] fcode,
  input  logic            isWrite,
  input  logic            probe,
  output ctrlStrobe_t     strobe
);

  localparam int DATA_BIT  = 0;
  localparam int PROG_BIT  = 1;
  localparam int SUPER_BIT = 2;

  always_comb begin
    strobe.selData   = fcode[DATA_BIT];
    strobe.selInst   = !fcode[DATA_BIT] && fcode[PROG_BIT];
    strobe.superMode = fcode[SUPER_BIT];
    strobe.writeChk  = isWrite && !probe;
    strobe.badFc     = !fcode[DATA_BIT] && !fcode[PROG_BIT];
  end

endmodule

// File: rtl/xlat_bypass_cmp.sv
module xlat_bypass_cmp
  import xlat_bypass_pkg::*;
#(
  parameter int BASE_W = 8
) (
  input  logic [WIN_W-1:0]  winReg,
  input  logic [BASE_W-1:0] addrTop,
  input  logic              superMode,
  output logic              match,
  output logic              wpBit
);

  logic [BASE_W-1:0] baseField;
  logic [BASE_W-1:0] maskField;
  winMode_t          modeField;
  logic              modeOk;
  logic              addrOk;
  logic              unusedBits;

  assign baseField  = winReg[BASE_HI -: BASE_W];
  assign maskField  = winReg[MASK_HI -: BASE_W];
  assign modeField  = winMode_t'(winReg[MODE_HI:MODE_LO]);
  assign unusedBits = ^{winReg[MODE_LO-1:WP_BIT+1], winReg[WP_BIT-1:0]};

  always_comb begin
    unique case (modeField)
      MODE_USER:  modeOk = !superMode;
      MODE_SUPER: modeOk = superMode;
      default:    modeOk = 1'b1;
    endcase
  end

  assign addrOk = ((addrTop ^ baseField) & ~maskField) == '0;
  assign match  = winReg[EN_BIT] && modeOk && addrOk;
  assign wpBit  = winReg[WP_BIT];

endmodule

// File: rtl/xlat_bypass_dp.sv
module xlat_bypass_dp
  import xlat_bypass_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2,
  parameter int BASE_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [ADDR_W-1:0]             laddr,
  input  ctrlStrobe_t                   strobe,
  input  logic [NUM_WIN-1:0][WIN_W-1:0] dataWin,
  input  logic [NUM_WIN-1:0][WIN_W-1:0] instWin,
  output logic                          hit,
  output logic [ADDR_W-1:0]             paddr,
  output logic                          busErr,
  output logic                          illegalFc
);

  logic [NUM_WIN-1:0] winMatch;
  logic [NUM_WIN-1:0] winWp;
  logic               anyHit;
  logic               selWp;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic [WIN_W-1:0] chosen;
    assign chosen = strobe.selData ? dataWin[i] : instWin[i];

    xlat_bypass_cmp #(.BASE_W(BASE_W)) u_cmp (
      .winReg    (chosen),
      .addrTop   (laddr[ADDR_W-1 -: BASE_W]),
      .superMode (strobe.superMode),
      .match     (winMatch[i]),
      .wpBit     (winWp[i])
    );
  end

  // Lowest index wins: scan downward so the last assignment is the lowest match.
  always_comb begin
    anyHit = 1'b0;
    selWp  = 1'b0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (winMatch[i]) begin
        anyHit = 1'b1;
        selWp  = winWp[i];
      end
    end
    if (strobe.badFc) begin
      anyHit = 1'b0;
      selWp  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hit       <= 1'b0;
      paddr     <= '0;
      busErr    <= 1'b0;
      illegalFc <= 1'b0;
    end else begin
      hit       <= anyHit;
      paddr     <= anyHit ? laddr : '0;
      busErr    <= anyHit && selWp && strobe.writeChk;
      illegalFc <= strobe.badFc;
    end
  end

endmodule

// File: rtl/xlat_bypass_top.sv
module xlat_bypass_top
  import xlat_bypass_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [31:0] laddr,
  input  logic [2:0]  fcode,
  input  logic        isWrite,
  input  logic        probe,
  input  logic [31:0] dataWin0,
  input  logic [31:0] dataWin1,
  input  logic [31:0] instWin0,
  input  logic [31:0] instWin1,
  output logic        hit,
  output logic [31:0] paddr,
  output logic        busErr,
  output logic        illegalFc
);

  localparam int ADDR_W  = 32;
  localparam int FC_W    = 3;
  localparam int NUM_WIN = 2;
  localparam int BASE_W  = 8;

  ctrlStrobe_t                   strobe;
  logic [NUM_WIN-1:0][WIN_W-1:0] dataSet;
  logic [NUM_WIN-1:0][WIN_W-1:0] instSet;

  assign dataSet = {dataWin1, dataWin0};
  assign instSet = {instWin1, instWin0};

  xlat_bypass_ctrl #(.FC_W(FC_W)) u_ctrl (
    .fcode   (fcode),
    .isWrite (isWrite),
    .probe   (probe),
    .strobe  (strobe)
  );

  xlat_bypass_dp #(
    .ADDR_W  (ADDR_W),
    .NUM_WIN (NUM_WIN),
    .BASE_W  (BASE_W)
  ) u_dp (
    .clk       (clk),
    .rst       (rst),
    .laddr     (laddr),
    .strobe    (strobe),
    .dataWin   (dataSet),
    .instWin   (instSet),
    .hit       (hit),
    .paddr     (paddr),
    .busErr    (busErr),
    .illegalFc (illegalFc)
  );

endmodule

// File: rtl/xlat_bypass_chk.sv
module xlat_bypass_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] laddr,
  input logic [2:0]  fcode,
  input logic        isWrite,
  input logic        probe,
  input logic        hit,
  input logic [31:0] paddr,
  input logic        busErr,
  input logic        illegalFc
);

  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= 1'b1;

  AST_RESET_CLEAR: assert property (@(posedge clk)
    (seen && $past(rst)) |-> (!hit && !busErr && !illegalFc && paddr == 32'd0)); // R1

  AST_ILLEGAL_NO_HIT: assert property (@(posedge clk) disable iff (rst)
    illegalFc |-> (!hit && !busErr)); // R3

  AST_ILLEGAL_FROM_FC: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(rst)) |-> (illegalFc == ($past(fcode[1:0]) == 2'b00))); // R3

  AST_FAULT_NEEDS_HIT: assert property (@(posedge clk) disable iff (rst)
    busErr |-> hit); // R9

  AST_PROBE_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (seen && $past(probe)) |-> !busErr); // R9

  AST_READ_NO_FAULT: assert property (@(posedge clk) disable iff (rst)
    (seen && !$past(isWrite)) |-> !busErr); // R9

  AST_PASS_ADDR: assert property (@(posedge clk) disable iff (rst)
    (seen && hit) |-> (paddr == $past(laddr))); // R8

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (paddr == 32'd0)); // R8

endmodule

bind xlat_bypass_top xlat_bypass_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .laddr     (laddr),
  .fcode     (fcode),
  .isWrite   (isWrite),
  .probe     (probe),
  .hit       (hit),
  .paddr     (paddr),
  .busErr    (busErr),
  .illegalFc (illegalFc)
);

// File: tb/xlat_bypass_top_tb.sv
`timescale 1ns/1ps
module xlat_bypass_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] laddr = '0;
  logic [2:0]  fcode = '0;
  logic        isWrite = 1'b0;
  logic        probe = 1'b0;
  logic [31:0] dataWin0 = '0, dataWin1 = '0, instWin0 = '0, instWin1 = '0;
  logic        hit, busErr, illegalFc;
  logic [31:0] paddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  xlat_bypass_top u_dut (
    .clk(clk), .rst(rst), .laddr(laddr), .fcode(fcode), .isWrite(isWrite),
    .probe(probe), .dataWin0(dataWin0), .dataWin1(dataWin1),
    .instWin0(instWin0), .instWin1(instWin1),
    .hit(hit), .paddr(paddr), .busErr(busErr), .illegalFc(illegalFc)
  );

  // Window register builder: enable bit 15, mode 14:13, wp bit 2, base 31:24, mask 23:16.
  function automatic logic [31:0] mkWin(bit en, logic [1:0] mode, bit wp,
                                        logic [7:0] base, logic [7:0] mask);
    logic [31:0] w = '0;
    w[31:24] = base; w[23:16] = mask; w[15] = en; w[14:13] = mode; w[2] = wp;
    return w;
  endfunction

  function automatic bit winHits(logic [31:0] w, logic [31:0] a, bit sup);
    bit modeOk;
    case (w[14:13])
      2'd0: modeOk = !sup;
      2'd1: modeOk = sup;
      default: modeOk = 1'b1;
    endcase
    return w[15] && modeOk && (((a[31:24] ^ w[31:24]) & ~w[23:16]) == 8'h00);
  endfunction

  logic        expHit, expErr, expIll;
  logic [31:0] expAddr;

  task automatic model();
    logic [31:0] w0, w1;
    bit sup = fcode[2];
    expIll = (fcode[1:0] == 2'b00);
    if (fcode[0]) begin w0 = dataWin0; w1 = dataWin1; end
    else          begin w0 = instWin0; w1 = instWin1; end
    expHit = 1'b0; expErr = 1'b0;
    if (!expIll) begin
      if (winHits(w0, laddr, sup)) begin
        expHit = 1'b1; expErr = w0[2] && isWrite && !probe;
      end else if (winHits(w1, laddr, sup)) begin
        expHit = 1'b1; expErr = w1[2] && isWrite && !probe;
      end
    end
    expAddr = expHit ? laddr : 32'd0;
  endtask

  task automatic compare(string tag, logic eh, logic ee, logic ei, logic [31:0] ea);
    checks++;
    if (hit !== eh || busErr !== ee || illegalFc !== ei || paddr !== ea) begin
      fails++;
      $display("FAIL %s: actual hit=%b err=%b ill=%b paddr=%h expected hit=%b err=%b ill=%b paddr=%h",
               tag, hit, busErr, illegalFc, paddr, eh, ee, ei, ea);
    end
  endtask

  // Called at a falling edge with inputs already set; checks one edge later.
  task automatic runVec(string tag);
    model();
    @(negedge clk);
    compare(tag, expHit, expErr, expIll, expAddr);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset with inputs that would hit.
    dataWin0 = mkWin(1, 2'd2, 1, 8'h40, 8'hFF);
    laddr = 32'h4000_1000; fcode = 3'b001; isWrite = 1'b1;
    repeat (3) @(negedge clk);
    compare("R1 reset clear", 0, 0, 0, 32'd0);
    rst = 1'b0;
    laddr = '0; fcode = 3'b001; isWrite = 1'b0; dataWin0 = '0;
    @(negedge clk);

    // R10: applied values show no effect before the next rising edge.
    dataWin0 = mkWin(1, 2'd2, 0, 8'h12, 8'h00);
    laddr = 32'h1234_5678; fcode = 3'b101;
    #1;
    compare("R10 no combinational path", 0, 0, 0, 32'd0);
    model();
    @(negedge clk);
    compare("R10 one-edge latency", expHit, expErr, expIll, expAddr);

    // R4: disabled window with matching fields never hits.
    dataWin0 = mkWin(0, 2'd2, 1, 8'h12, 8'hFF); dataWin1 = '0;
    laddr = 32'h1234_0000; isWrite = 1'b1;
    runVec("R4 disabled window");
    compare("R4 disabled no hit", 0, 0, 0, 32'd0);

    // R5: every upper byte against base A5 with low nibble masked.
    dataWin0 = mkWin(1, 2'd3, 0, 8'hA5, 8'h0F); dataWin1 = '0; isWrite = 1'b0;
    for (int b = 0; b < 256; b++) begin
      laddr = {b[7:0], 24'h00_BEEF};
      runVec("R5 mask sweep");
      if (((b[7:0] ^ 8'hA5) & 8'hF0) == 8'h00 && hit !== 1'b1) begin
        checks++; fails++;
        $display("FAIL R5 masked byte %h: actual hit=%b expected 1", b[7:0], hit);
      end
    end

    // R7: both windows hit; window 0 clear WP, window 1 WP -> no fault.
    dataWin0 = mkWin(1, 2'd2, 0, 8'h33, 8'h00);
    dataWin1 = mkWin(1, 2'd2, 1, 8'h33, 8'h00);
    laddr = 32'h3300_0040; fcode = 3'b001; isWrite = 1'b1; probe = 1'b0;
    runVec("R7 priority window0");
    compare("R7 window0 decides", 1, 0, 0, 32'h3300_0040);

    // R9: probe suppresses the fault; a plain write raises it.
    dataWin0 = mkWin(1, 2'd2, 1, 8'h33, 8'h00);
    probe = 1'b1;
    runVec("R9 probe no fault");
    compare("R9 probe hit", 1, 0, 0, 32'h3300_0040);
    probe = 1'b0;
    runVec("R9 write fault");
    compare("R9 write faults", 1, 1, 0, 32'h3300_0040);

    // R3: illegal function codes 0 and 4.
    fcode = 3'b100;
    runVec("R3 illegal fc");
    compare("R3 illegal flag", 0, 0, 1, 32'd0);

    // R2/R4/R5/R6/R7/R8/R9 sweep. Instruction set placed elsewhere so selection matters.
    instWin0 = mkWin(1, 2'd2, 1, 8'hC0, 8'h00);
    instWin1 = mkWin(1, 2'd0, 0, 8'h41, 8'h00);
    for (int f = 0; f < 8; f++)
      for (int m = 0; m < 4; m++)
        for (int e = 0; e < 2; e++)
          for (int k = 0; k < 8; k++)
            for (int a = 0; a < 4; a++) begin
              dataWin0 = mkWin(e[0], m[1:0], k[0], 8'h40, 8'h00);
              dataWin1 = mkWin(1, 2'd2, !k[0], 8'h40, 8'h01);
              isWrite = k[1]; probe = k[2]; fcode = f[2:0];
              case (a)
                0: laddr = 32'h4012_3456;
                1: laddr = 32'h41FF_0000;
                2: laddr = 32'hC000_0010;
                default: laddr = 32'h7F00_0004;
              endcase
              runVec("R2 R6 R8 sweep");
            end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule